// File: doc/BRIEF.md
# Dual Comparator Control and Status Register Block

This block is the digital side of a pair of analog comparators. Software reaches it through a 32-bit APB slave with no wait states. Through it, software turns each comparator on, arms its interrupt and picks its reference source. For channel 0 it also picks which port-B pad feeds the positive input. The comparators, references and pad multiplexers sit outside the block. Here they appear only as two raw input bits and a set of select outputs.

Each raw comparator bit is asynchronous to the bus clock. It passes through a two-flop synchronizer and is then compared against a third registered copy, which exposes every transition in either direction. A detected transition sets a sticky per-channel change flag, and software clears that flag by writing a 1 to it. A flag combined with its channel's interrupt enable drives that channel's interrupt line. While a channel is disabled, its synchronized level reads back as zero and its change flag cannot be set.

Top module: `dual_cmp_regif`

## Requirements
- R1: After reset, every register reads 0, and `cmp_en`, `cmp_nsel`, `pos_sel` and `irq` are all 0.
- R2: The channel control words sit at offset 0x0 (channel 0) and 0x4 (channel 1). In each, bit 0 enables the channel, bit 1 enables its interrupt and bit 4 selects the negative input source. Bits 0 and 4 are driven on `cmp_en[ch]` and `cmp_nsel[ch]`. All other bits read as 0.
- R3: The word at offset 0xC holds a 3-bit pad index in bits [2:0], which is driven on `pos_sel`. All higher bits read as 0.
- R4: In the status word at offset 0x8, bit 0 (channel 0) and bit 1 (channel 1) are change flags. A flag is set when its enabled channel's synchronized level rises or falls. A flag is never set while its channel is disabled, nor by the act of enabling it.
- R5: Writing 1 to a flag bit clears it, and writing 0 leaves it as it is. If a detected change and a clearing write reach the same flag on the same clock edge, the flag ends up set.
- R6: `irq[ch]` is high one cycle after that channel's flag and interrupt enable are both 1. It drops one cycle after either of them is 0.
- R7: Status bits 2 and 3 return the synchronized level of channels 0 and 1. A raw change is visible two clock edges later. The bit reads 0 while its channel is disabled. Writes to these bits have no effect.
- R8: An access at offset 0x10 or above reads 0, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, registered in the setup phase |
| cmp_raw | input | 2 | Asynchronous comparator outputs |
| cmp_en | output | 2 | Per-channel comparator enable |
| cmp_nsel | output | 2 | Per-channel negative input select |
| pos_sel | output | 3 | Pad index for channel 0 positive input |
| irq | output | 2 | Per-channel interrupt |

## Verification
The embedded properties guard the following on every cycle:
- a set flag stays set until a clearing write;
- a detected change always leaves the flag set on the next edge;
- a disabled channel never gains a flag;
- the interrupt tracks the flag and enable one cycle late;
- status reads of a disabled channel's level, and reads beyond the map, return zero.

Only the bench scenarios can show the rest: the bit layout of each word, the two-edge synchronizer latency in both directions, write-0 leaving a flag alone, and the exact-cycle collision where a change and a clear coincide.

// File: rtl/cmpw_pkg.sv
package cmpw_pkg;
  parameter int DATA_W = 32;
  parameter int NCH    = 2;
  parameter int SEL_W  = 3;

  localparam logic [1:0] IDX_CTL0 = 2'd0;
  localparam logic [1:0] IDX_CTL1 = 2'd1;
  localparam logic [1:0] IDX_STAT = 2'd2;
  localparam logic [1:0] IDX_SEL  = 2'd3;

  localparam int B_EN   = 0;
  localparam int B_IE   = 1;
  localparam int B_NSEL = 4;
  localparam int B_LVL  = 2;   // status: level bits start here

  typedef struct packed {
    logic en;
    logic ie;
    logic nsel;
  } chan_ctl_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= 1'b0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic en,
  input  logic ie,
  input  logic clr,
  output logic lvl,
  output logic flag,
  output logic irq
);
  logic synced, prev_q, en_d, chg, flag_q, irq_q;

  cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      en_d   <= 1'b0;
    end else begin
      prev_q <= synced;
      en_d   <= en;
    end
  end

  assign chg = en & en_d & (synced ^ prev_q);

  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (chg) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_q & ie;
  end

  assign lvl  = en & synced;
  assign flag = flag_q;
  assign irq  = irq_q;

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    chg |=> flag_q);
  p_no_flag_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!en && !flag_q) |=> !flag_q);
  p_irq_on_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && ie) |=> irq_q);
  p_irq_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!flag_q || !ie) |=> !irq_q);
endmodule

// File: rtl/dual_cmp_regif.sv
module dual_cmp_regif
  import cmpw_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [NCH-1:0]    cmp_raw,
  output logic [NCH-1:0]    cmp_en,
  output logic [NCH-1:0]    cmp_nsel,
  output logic [SEL_W-1:0]  pos_sel,
  output logic [NCH-1:0]    irq
);
  localparam int HI_W = ADDR_W - 4;

  chan_ctl_t        ctl_q [NCH];
  logic [SEL_W-1:0] sel_q;
  logic [NCH-1:0]   lvl, flag, clr;
  logic             in_map, wr_acc, rd_setup;
  logic [1:0]       idx;
  logic [DATA_W-1:0] rmux;
  logic             unused_bits;

  assign in_map   = (paddr[ADDR_W-1:4] == {HI_W{1'b0}});
  assign idx      = paddr[3:2];
  assign wr_acc   = psel & penable & pwrite & in_map;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign unused_bits = ^{pwdata[DATA_W-1:5], pwdata[3], paddr[1:0]};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [1:0] MY_IDX = (c == 0) ? IDX_CTL0 : IDX_CTL1;

      always_ff @(posedge clk) begin
        if (rst) ctl_q[c] <= '0;
        else if (wr_acc && idx == MY_IDX) begin
          ctl_q[c].en   <= pwdata[B_EN];
          ctl_q[c].ie   <= pwdata[B_IE];
          ctl_q[c].nsel <= pwdata[B_NSEL];
        end
      end

      assign clr[c]      = wr_acc & (idx == IDX_STAT) & pwdata[c];
      assign cmp_en[c]   = ctl_q[c].en;
      assign cmp_nsel[c] = ctl_q[c].nsel;

      cmp_chan #(.SYNC_STAGES(SYNC_STAGES)) i_chan (
        .clk(clk), .rst(rst), .raw(cmp_raw[c]),
        .en(ctl_q[c].en), .ie(ctl_q[c].ie), .clr(clr[c]),
        .lvl(lvl[c]), .flag(flag[c]), .irq(irq[c])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (wr_acc && idx == IDX_SEL) sel_q <= pwdata[SEL_W-1:0];
  end
  assign pos_sel = sel_q;

  always_comb begin
    rmux = '0;
    if (in_map) begin
      case (idx)
        IDX_CTL0, IDX_CTL1: begin
          rmux[B_EN]   = ctl_q[idx[0]].en;
          rmux[B_IE]   = ctl_q[idx[0]].ie;
          rmux[B_NSEL] = ctl_q[idx[0]].nsel;
        end
        IDX_STAT: begin
          rmux[NCH-1:0]           = flag;
          rmux[B_LVL +: NCH]      = lvl;
        end
        default: rmux[SEL_W-1:0] = sel_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prdata <= '0;
    else if (rd_setup) prdata <= rmux;
  end

  p_lvl_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && in_map && idx == IDX_STAT && !cmp_en[0]) |=> !prdata[B_LVL]);
  p_oob_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && !in_map) |=> (prdata == '0));
endmodule

// File: tb/test_dual_cmp_regif.sv
module test_dual_cmp_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0]  cmp_raw = '0;
  logic [1:0]  cmp_en, cmp_nsel, irq;
  logic [2:0]  pos_sel;

  int total = 0;
  int bad   = 0;

  typedef struct { logic [31:0] exp; int req; logic [7:0] addr; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  dual_cmp_regif i_dual_cmp_regif (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cmp_raw(cmp_raw),
    .cmp_en(cmp_en), .cmp_nsel(cmp_nsel), .pos_sel(pos_sel), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic apb_read(input logic [7:0] a, input logic [31:0] e, input int req);
    item_t it;
    it.exp = e; it.req = req; it.addr = a;
    sb_q.push_back(it);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // monitor: compare completed reads against the scoreboard
  always begin
    @(posedge clk);
    #1;
    if (psel && penable && !pwrite) begin
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R0 unexpected read: actual=0x%0h expected=none", prdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(prdata, it.exp, it.req, $sformatf("read @0x%0h", it.addr));
      end
    end
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL R0 watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    apb_read(8'h00, 32'h0, 1);
    apb_read(8'h04, 32'h0, 1);
    apb_read(8'h08, 32'h0, 1);
    apb_read(8'h0C, 32'h0, 1);
    check({cmp_en, cmp_nsel, irq, 1'b0, pos_sel}, 32'h0, 1, "outputs after reset");

    // R2: control layout
    apb_write(8'h00, 32'hFFFF_FFFF);
    apb_read(8'h00, 32'h13, 2);
    check(cmp_en[0], 1, 2, "cmp_en0");
    check(cmp_nsel[0], 1, 2, "cmp_nsel0");
    apb_write(8'h04, 32'h10);
    apb_read(8'h04, 32'h10, 2);
    check({cmp_en[1], cmp_nsel[1]}, 32'h1, 2, "ch1 en/nsel");
    apb_write(8'h00, 32'h1);
    apb_write(8'h04, 32'h3);

    // R3: select word
    apb_write(8'h0C, 32'hFFFF_FFFD);
    apb_read(8'h0C, 32'h5, 3);
    check(pos_sel, 3'd5, 3, "pos_sel");

    // R4 / R7: rising change on ch0
    idle(4);
    apb_read(8'h08, 32'h0, 4);
    cmp_raw[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);  // two edges: level visible now
    apb_read(8'h08, 32'h4, 7);  // captured at third edge: flag just set by it? level read
    idle(3);
    apb_read(8'h08, 32'h5, 4);
    check(irq[0], 0, 6, "irq0 masked by ie=0");

    // R5: write 0 keeps, write 1 clears
    apb_write(8'h08, 32'h0);
    apb_read(8'h08, 32'h5, 5);
    apb_write(8'h08, 32'h1);
    apb_read(8'h08, 32'h4, 5);

    // R4: falling change
    cmp_raw[0] = 1'b0;
    idle(5);
    apb_read(8'h08, 32'h1, 4);
    apb_write(8'h08, 32'h1);
    apb_read(8'h08, 32'h0, 5);

    // R6: interrupt on ch1
    cmp_raw[1] = 1'b1;
    idle(5);
    check(irq[1], 1, 6, "irq1 raised");
    apb_read(8'h08, 32'hA, 4);
    apb_write(8'h04, 32'h1);
    idle(1);
    check(irq[1], 0, 6, "irq1 with ie off");
    apb_write(8'h04, 32'h3);
    idle(1);
    check(irq[1], 1, 6, "irq1 ie back on");
    apb_write(8'h08, 32'h2);
    idle(1);
    check(irq[1], 0, 6, "irq1 after clear");

    // R7: level bits ignore writes, zero when disabled
    apb_write(8'h08, 32'hC);
    apb_read(8'h08, 32'h8, 7);
    apb_write(8'h04, 32'h0);
    apb_read(8'h08, 32'h0, 7);

    // R4: no flag while disabled, nor on enabling
    cmp_raw[1] = 1'b0;
    idle(5);
    cmp_raw[1] = 1'b1;
    idle(5);
    apb_read(8'h08, 32'h0, 4);
    apb_write(8'h04, 32'h1);
    idle(5);
    apb_read(8'h08, 32'h8, 4);

    // R5: change and clear on the same edge -> flag set
    cmp_raw[0] = 1'b1;
    @(negedge clk);
    apb_write(8'h08, 32'h1);
    apb_read(8'h08, 32'hD, 5);

    // R8: beyond the map
    apb_write(8'h10, 32'hFF);
    apb_write(8'h30, 32'hFF);
    apb_read(8'h10, 32'h0, 8);
    apb_read(8'h3C, 32'h0, 8);
    apb_read(8'h00, 32'h1, 8);
    apb_read(8'h0C, 32'h5, 8);
    check(pos_sel, 3'd5, 8, "pos_sel after out-of-map write");

    idle(3);
    check(sb_q.size(), 0, 0, "scoreboard drained");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule